// File: doc/BRIEF.md
# Fixed-Latency Trigger Dispatcher

This block sits at the output of a trigger selector. It takes accepted trigger records, each tagged with a timestamp, and plays them out after a fixed, programmable delay. Every record is written into a circular slot buffer. The buffer is indexed by the low bits of its timestamp, so records leave in time order whatever order they arrived in. Each clock edge is one tick of the experiment's master clock. A start-of-burst pulse restarts the tick count and empties the buffer. The read pointer waits until the programmed latency has gone by. From then on it moves one slot per tick, so the record in slot X is read at tick X plus latency.

Playout passes through an arbiter before it leaves the block. The arbiter keeps emitted triggers a minimum number of ticks apart and suppresses normal triggers while any choke or error line is high. It inserts an immediate marker trigger when the choke condition begins and another when it ends. It also throttles itself when the emitted rate over a window goes above a set maximum. Every emitted trigger is presented on a detector-side strobe and on an identical host-side record port.

Top module: `trig_dispatch`

## Requirements
- R1: A record written with `in_ts` lands in slot `in_ts[ADDR_W-1:0]`. When it is played out it carries its full timestamp and payload and has kind 0 (normal). Kind codes: 0 normal, 1 choke start, 2 choke end.
- R2: The read pointer stays still until the tick count since start of burst equals `latency`. The strobe for the record in slot X appears after the clock edge numbered `latency + X + 2`, counting the edge that samples `sob` as edge 0.
- R3: A slot is empty once it has been read, so the pointer passing it again after wrapping produces no trigger. A start-of-burst pulse empties every slot.
- R4: Any two output strobes are at least DEAD edges apart (3 by default).
- R5: A buffered record that the dead time blocks goes into a one-entry hold and leaves at the first edge the dead time allows. A record that arrives while the hold is full and not leaving is dropped, and `drop_count` goes up by one.
- R6: Each choke/error input passes through two synchronizing flops, and the results are ORed into `choke_active`. While `choke_active` is high, no normal trigger is emitted, and records read in that time are discarded without being counted as drops.
- R7: A kind-1 marker is emitted at the third edge after the OR of the choke inputs rises, and a kind-2 marker at the third edge after it falls. Markers carry timestamp 0 and payload 0. Overlapping choke inputs produce one start marker and one end marker.
- R8: When a marker and a buffered record are both due in the same cycle, the marker goes first. The record is held and then emitted once the dead time has passed.
- R9: A rate window of RATE_WIN edges restarts at start of burst. Once `rate_max` triggers have been emitted in the window, `auto_choke` goes high and normal triggers are suppressed until the window rolls over. A `rate_max` of 0 turns the limit off.
- R10: The host record port (`host_valid`, `host_kind`, `host_ts`, `host_payload`) matches the detector port in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| sob | input | 1 | Start-of-burst pulse |
| latency | input | LAT_W | Fixed playout delay in ticks |
| rate_max | input | RCNT_W | Triggers allowed per rate window, 0 = no limit |
| in_valid | input | 1 | Record write strobe |
| in_ts | input | TS_W | Record timestamp |
| in_payload | input | PAY_W | Record payload |
| choke_in | input | N_CHOKE | Asynchronous choke/error lines |
| det_strobe | output | 1 | Detector trigger strobe |
| det_kind | output | 2 | Trigger kind |
| det_ts | output | TS_W | Trigger timestamp |
| det_payload | output | PAY_W | Trigger payload |
| host_valid | output | 1 | Host record valid |
| host_kind | output | 2 | Host record kind |
| host_ts | output | TS_W | Host record timestamp |
| host_payload | output | PAY_W | Host record payload |
| choke_active | output | 1 | Synchronized choke state |
| auto_choke | output | 1 | Rate limiter engaged |
| drop_count | output | DROP_W | Records dropped by dead-time congestion |

## Verification
The hardest situation to reach is a marker and a buffered record falling due in exactly the same cycle while the choke is releasing. The bench times the fall of the choke inputs so that the end marker's arbitration edge coincides with the playout edge of a chosen slot, and it uses the latency and slot number to put that record there. The dead-time hold and drop path is reached by writing adjacent slots, so that reads arrive on consecutive edges. The buffer-wrap case is reached by waiting a full pointer revolution after playout.

// File: rtl/trig_dispatch_pkg.sv
package trig_dispatch_pkg;
  typedef enum logic [1:0] {
    K_NORM  = 2'd0,
    K_START = 2'd1,
    K_END   = 2'd2
  } trig_kind_e;
endpackage

// File: rtl/td_choke_sync.sv
module td_choke_sync #(
  parameter int N_CHOKE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CHOKE-1:0] choke_in,
  output logic               lvl,
  output logic               rise,
  output logic               fall
);
  logic [N_CHOKE-1:0] meta_q, sync_q;
  logic               lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      lvl_d  <= 1'b0;
    end else begin
      meta_q <= choke_in;
      sync_q <= meta_q;
      lvl_d  <= |sync_q;
    end
  end

  assign lvl  = |sync_q;
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  // R7: an edge pulse lasts one cycle only
  assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/td_slot_buffer.sv
module td_slot_buffer #(
  parameter int TS_W   = 24,
  parameter int PAY_W  = 16,
  parameter int ADDR_W = 8,
  parameter int LAT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sob,
  input  logic [LAT_W-1:0] latency,
  input  logic             wr_en,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic [PAY_W-1:0] wr_pay,
  output logic             rd_hit,
  output logic [TS_W-1:0]  rd_ts,
  output logic [PAY_W-1:0] rd_pay
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int EW    = TS_W + PAY_W;

  logic [EW-1:0]     mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [EW-1:0]     rd_q;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] wr_addr;
  logic [LAT_W-1:0]  tick;
  logic              running, armed, rd_en;

  assign wr_addr = wr_ts[ADDR_W-1:0];
  assign rd_en   = running & ~sob & (armed | (tick == latency));

  // data array: no reset, single write and single read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_ts, wr_pay};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || sob) begin
      vld    <= '0;
      rd_hit <= 1'b0;
    end else begin
      rd_hit <= rd_en & vld[rd_ptr];
      if (rd_en) vld[rd_ptr] <= 1'b0;
      if (wr_en) vld[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      running <= 1'b0;
      armed   <= 1'b0;
      rd_ptr  <= '0;
    end else if (sob) begin
      tick    <= '0;
      running <= 1'b1;
      armed   <= 1'b0;
      rd_ptr  <= '0;
    end else if (running) begin
      if (!armed) begin
        if (tick == latency) armed <= 1'b1;
        else                 tick  <= tick + 1'b1;
      end
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_ts  = rd_q[EW-1:PAY_W];
  assign rd_pay = rd_q[PAY_W-1:0];

  // R2: pointer idle while the latency is still counting
  assert_ptr_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!sob && !armed && tick != latency) |=> (rd_ptr == $past(rd_ptr)));

  // R3: a slot read without a concurrent write to it is empty afterwards
  assert_slot_cleared_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && wr_addr == rd_ptr)) |=> !vld[$past(rd_ptr)]);
endmodule

// File: rtl/td_arbiter.sv
module td_arbiter
  import trig_dispatch_pkg::*;
#(
  parameter int TS_W     = 24,
  parameter int PAY_W    = 16,
  parameter int DEAD     = 3,
  parameter int RATE_WIN = 400,
  parameter int RCNT_W   = 8,
  parameter int DROP_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sob,
  input  logic [RCNT_W-1:0] rate_max,
  input  logic              fresh_v,
  input  logic [TS_W-1:0]   fresh_ts,
  input  logic [PAY_W-1:0]  fresh_pay,
  input  logic              choke_lvl,
  input  logic              choke_rise,
  input  logic              choke_fall,
  output logic              det_strobe,
  output logic [1:0]        det_kind,
  output logic [TS_W-1:0]   det_ts,
  output logic [PAY_W-1:0]  det_payload,
  output logic              host_valid,
  output logic [1:0]        host_kind,
  output logic [TS_W-1:0]   host_ts,
  output logic [PAY_W-1:0]  host_payload,
  output logic              auto_choke,
  output logic [DROP_W-1:0] drop_count
);
  localparam int SW = $clog2(DEAD + 1);
  localparam int WW = (RATE_WIN > 1) ? $clog2(RATE_WIN) : 1;
  localparam logic [SW-1:0] SINCE_OK = SW'(DEAD - 1);

  logic [SW-1:0]     since;
  logic              pend_s, pend_e;
  logic              hold_v;
  logic [TS_W-1:0]   hold_ts;
  logic [PAY_W-1:0]  hold_pay;
  logic [WW-1:0]     win;
  logic [RCNT_W-1:0] rcnt;

  logic dead_ok, sup, want_s, want_e;
  logic emit_s, emit_e, emit_h, emit_f, emit_any, to_hold, drop;

  always_comb begin
    dead_ok  = (since >= SINCE_OK);
    sup      = choke_lvl | auto_choke;
    want_s   = pend_s | choke_rise;
    want_e   = pend_e | choke_fall;
    emit_s   = dead_ok & want_s;
    emit_e   = dead_ok & ~want_s & want_e;
    emit_h   = dead_ok & ~want_s & ~want_e & hold_v & ~sup;
    emit_f   = dead_ok & ~want_s & ~want_e & ~hold_v & fresh_v & ~sup;
    emit_any = emit_s | emit_e | emit_h | emit_f;
    to_hold  = fresh_v & ~sup & ~emit_f & (~hold_v | emit_h);
    drop     = fresh_v & ~sup & ~emit_f & hold_v & ~emit_h;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since  <= SINCE_OK;
      pend_s <= 1'b0;
      pend_e <= 1'b0;
      hold_v <= 1'b0;
    end else begin
      if (emit_any)             since <= '0;
      else if (since != SINCE_OK) since <= since + 1'b1;
      pend_s <= want_s & ~emit_s;
      pend_e <= want_e & ~emit_e;
      if (sup)          hold_v <= 1'b0;
      else if (to_hold) hold_v <= 1'b1;
      else if (emit_h)  hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (to_hold) begin
      hold_ts  <= fresh_ts;
      hold_pay <= fresh_pay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_count <= '0;
    end else if (drop) begin
      drop_count <= drop_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sob) begin
      win        <= '0;
      rcnt       <= '0;
      auto_choke <= 1'b0;
    end else if (win == WW'(RATE_WIN - 1)) begin
      win        <= '0;
      rcnt       <= '0;
      auto_choke <= 1'b0;
    end else begin
      win <= win + 1'b1;
      if (emit_any) begin
        rcnt <= rcnt + 1'b1;
        if (rate_max != '0 && (rcnt + 1'b1) >= rate_max) auto_choke <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_strobe   <= 1'b0;
      det_kind     <= K_NORM;
      det_ts       <= '0;
      det_payload  <= '0;
      host_valid   <= 1'b0;
      host_kind    <= K_NORM;
      host_ts      <= '0;
      host_payload <= '0;
    end else begin
      det_strobe <= emit_any;
      host_valid <= emit_any;
      if (emit_s || emit_e) begin
        det_kind     <= emit_s ? K_START : K_END;
        host_kind    <= emit_s ? K_START : K_END;
        det_ts       <= '0;
        host_ts      <= '0;
        det_payload  <= '0;
        host_payload <= '0;
      end else if (emit_h || emit_f) begin
        det_kind     <= K_NORM;
        host_kind    <= K_NORM;
        det_ts       <= emit_h ? hold_ts : fresh_ts;
        host_ts      <= emit_h ? hold_ts : fresh_ts;
        det_payload  <= emit_h ? hold_pay : fresh_pay;
        host_payload <= emit_h ? hold_pay : fresh_pay;
      end
    end
  end

  generate
    if (DEAD >= 3) begin : g_gap3
      // R4: no strobe within two edges of the previous one
      assert_dead_gap_R4: assert property (@(posedge clk) disable iff (rst)
        det_strobe |-> (!$past(det_strobe) && !$past(det_strobe, 2)));
    end
  endgenerate

  // R6: a normal trigger never leaves while the choke level was high
  assert_choke_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (det_strobe && det_kind == K_NORM) |-> !$past(choke_lvl));

  // R9: rate limiter blocks normal triggers
  assert_auto_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (det_strobe && det_kind == K_NORM) |-> !$past(auto_choke));

  // R5: a drop raises the counter by exactly one
  assert_drop_count_R5: assert property (@(posedge clk) disable iff (rst)
    drop |=> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: rtl/trig_dispatch.sv
module trig_dispatch #(
  parameter int TS_W     = 24,
  parameter int PAY_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int LAT_W    = 16,
  parameter int DEAD     = 3,
  parameter int RATE_WIN = 400,
  parameter int RCNT_W   = 8,
  parameter int DROP_W   = 16,
  parameter int N_CHOKE  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sob,
  input  logic [LAT_W-1:0]   latency,
  input  logic [RCNT_W-1:0]  rate_max,
  input  logic               in_valid,
  input  logic [TS_W-1:0]    in_ts,
  input  logic [PAY_W-1:0]   in_payload,
  input  logic [N_CHOKE-1:0] choke_in,
  output logic               det_strobe,
  output logic [1:0]         det_kind,
  output logic [TS_W-1:0]    det_ts,
  output logic [PAY_W-1:0]   det_payload,
  output logic               host_valid,
  output logic [1:0]         host_kind,
  output logic [TS_W-1:0]    host_ts,
  output logic [PAY_W-1:0]   host_payload,
  output logic               choke_active,
  output logic               auto_choke,
  output logic [DROP_W-1:0]  drop_count
);
  logic             rd_hit;
  logic [TS_W-1:0]  rd_ts;
  logic [PAY_W-1:0] rd_pay;
  logic             ch_rise, ch_fall;

  td_choke_sync #(.N_CHOKE(N_CHOKE)) u_sync (
    .clk(clk), .rst(rst), .choke_in(choke_in),
    .lvl(choke_active), .rise(ch_rise), .fall(ch_fall)
  );

  td_slot_buffer #(.TS_W(TS_W), .PAY_W(PAY_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_buf (
    .clk(clk), .rst(rst), .sob(sob), .latency(latency),
    .wr_en(in_valid), .wr_ts(in_ts), .wr_pay(in_payload),
    .rd_hit(rd_hit), .rd_ts(rd_ts), .rd_pay(rd_pay)
  );

  td_arbiter #(.TS_W(TS_W), .PAY_W(PAY_W), .DEAD(DEAD), .RATE_WIN(RATE_WIN),
               .RCNT_W(RCNT_W), .DROP_W(DROP_W)) u_arb (
    .clk(clk), .rst(rst), .sob(sob), .rate_max(rate_max),
    .fresh_v(rd_hit), .fresh_ts(rd_ts), .fresh_pay(rd_pay),
    .choke_lvl(choke_active), .choke_rise(ch_rise), .choke_fall(ch_fall),
    .det_strobe(det_strobe), .det_kind(det_kind), .det_ts(det_ts), .det_payload(det_payload),
    .host_valid(host_valid), .host_kind(host_kind), .host_ts(host_ts), .host_payload(host_payload),
    .auto_choke(auto_choke), .drop_count(drop_count)
  );
endmodule

// File: tb/trig_dispatch_tb.sv
module trig_dispatch_tb;
  localparam int TS_W = 24, PAY_W = 16, ADDR_W = 8, LAT_W = 16;
  localparam int RCNT_W = 8, DROP_W = 16, NC = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sob, in_valid;
  logic [LAT_W-1:0]  latency;
  logic [RCNT_W-1:0] rate_max;
  logic [TS_W-1:0]   in_ts;
  logic [PAY_W-1:0]  in_payload;
  logic [NC-1:0]     choke_in;
  logic              det_strobe, host_valid, choke_active, auto_choke;
  logic [1:0]        det_kind, host_kind;
  logic [TS_W-1:0]   det_ts, host_ts;
  logic [PAY_W-1:0]  det_payload, host_payload;
  logic [DROP_W-1:0] drop_count;

  trig_dispatch #(.TS_W(TS_W), .PAY_W(PAY_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W),
                  .DEAD(3), .RATE_WIN(64), .RCNT_W(RCNT_W), .DROP_W(DROP_W),
                  .N_CHOKE(NC)) u_dut (
    .clk(clk), .rst(rst), .sob(sob), .latency(latency), .rate_max(rate_max),
    .in_valid(in_valid), .in_ts(in_ts), .in_payload(in_payload), .choke_in(choke_in),
    .det_strobe(det_strobe), .det_kind(det_kind), .det_ts(det_ts), .det_payload(det_payload),
    .host_valid(host_valid), .host_kind(host_kind), .host_ts(host_ts), .host_payload(host_payload),
    .choke_active(choke_active), .auto_choke(auto_choke), .drop_count(drop_count)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, host_bad = 0, ev_n = 0;
  int ev_cyc [256];
  int ev_kind[256];
  int ev_ts  [256];
  int ev_pay [256];
  int ex_cyc [64];
  int ex_kind[64];
  int ex_ts  [64];
  int ex_pay [64];
  int ex_n;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (det_strobe !== host_valid ||
          (det_strobe && (det_kind !== host_kind || det_ts !== host_ts ||
                          det_payload !== host_payload)))
        host_bad <= host_bad + 1;
      if (det_strobe && ev_n < 256) begin
        ev_cyc[ev_n]  <= cyc;
        ev_kind[ev_n] <= int'(det_kind);
        ev_ts[ev_n]   <= int'(det_ts);
        ev_pay[ev_n]  <= int'(det_payload);
        ev_n <= ev_n + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_sob(input int lat, input int rmax, output int s);
    @(negedge clk);
    latency = LAT_W'(lat);
    rate_max = RCNT_W'(rmax);
    sob = 1'b1;
    @(negedge clk);
    sob = 1'b0;
    s = cyc;
  endtask

  task automatic put(input int slot, input int pay);
    in_valid = 1'b1;
    in_ts = {16'hC3A5, 8'(slot)};
    in_payload = PAY_W'(pay);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ev(input int c, input int k, input int slot, input int pay);
    ex_cyc[ex_n] = c;
    ex_kind[ex_n] = k;
    ex_ts[ex_n] = (k == 0) ? int'({16'hC3A5, 8'(slot)}) : 0;
    ex_pay[ex_n] = (k == 0) ? pay : 0;
    ex_n++;
  endtask

  task automatic compare(input string req, input int base);
    chk({req, " event count"}, ev_n - base, ex_n);
    for (int i = 0; i < ex_n && base + i < ev_n; i++) begin
      chk({req, " strobe cycle"}, ev_cyc[base+i], ex_cyc[i]);
      chk({req, " kind"}, ev_kind[base+i], ex_kind[i]);
      chk({req, " timestamp"}, ev_ts[base+i], ex_ts[i]);
      chk({req, " payload"}, ev_pay[base+i], ex_pay[i]);
    end
  endtask

  initial begin
    int s, base, d0;
    int lats[4] = '{3, 9, 40, 130};
    rst = 1'b1; sob = 1'b0; in_valid = 1'b0; in_ts = '0; in_payload = '0;
    latency = '0; rate_max = '0; choke_in = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset strobe", int'(det_strobe), 0);
    chk("R10 reset host", int'(host_valid), 0);
    chk("R5 reset drops", int'(drop_count), 0);
    chk("R9 reset auto", int'(auto_choke), 0);
    chk("R6 reset choke", int'(choke_active), 0);

    // R1 R2 R3: latency sweep, slots every 5, then wait a full pointer wrap
    foreach (lats[j]) begin
      base = ev_n; ex_n = 0;
      do_sob(lats[j], 0, s);
      for (int x = 0; x <= 60; x += 5) put(x, lats[j] * 256 + x);
      for (int x = 0; x <= 60; x += 5) expect_ev(s + lats[j] + x + 2, 0, x, lats[j] * 256 + x);
      wait_cyc(s + lats[j] + 2 + 256 + 80);
      compare("R1 R2 R3 sweep", base);
    end

    // R3: start of burst empties the buffer
    base = ev_n; ex_n = 0;
    do_sob(200, 0, s);
    put(3, 77);
    do_sob(5, 0, s);
    put(7, 88);
    expect_ev(s + 5 + 7 + 2, 0, 7, 88);
    wait_cyc(s + 40);
    compare("R3 sob clear", base);

    // R4 R5: adjacent slots, hold and drop
    base = ev_n; ex_n = 0; d0 = int'(drop_count);
    do_sob(20, 0, s);
    put(10, 1); put(11, 2); put(12, 3); put(13, 4); put(20, 5); put(22, 6);
    expect_ev(s + 32, 0, 10, 1);
    expect_ev(s + 35, 0, 11, 2);
    expect_ev(s + 38, 0, 13, 4);
    expect_ev(s + 42, 0, 20, 5);
    expect_ev(s + 45, 0, 22, 6);
    wait_cyc(s + 80);
    compare("R4 R5 dead time", base);
    chk("R5 drop count", int'(drop_count) - d0, 1);

    // R6 R7 R8: overlapping chokes, marker priority at release
    base = ev_n; ex_n = 0; d0 = int'(drop_count);
    do_sob(20, 0, s);
    put(5, 11); put(11, 12); put(20, 13); put(41, 14); put(50, 15);
    wait_cyc(s + 30); choke_in[1] = 1'b1;
    wait_cyc(s + 40); choke_in[0] = 1'b1;
    wait_cyc(s + 45);
    chk("R6 choke_active high", int'(choke_active), 1);
    wait_cyc(s + 50); choke_in[1] = 1'b0;
    wait_cyc(s + 60); choke_in[0] = 1'b0;
    expect_ev(s + 27, 0, 5, 11);
    expect_ev(s + 33, 1, 0, 0);
    expect_ev(s + 63, 2, 0, 0);
    expect_ev(s + 66, 0, 41, 14);
    expect_ev(s + 72, 0, 50, 15);
    wait_cyc(s + 100);
    compare("R6 R7 R8 choke", base);
    chk("R6 no drop counted", int'(drop_count) - d0, 0);
    chk("R6 choke_active low", int'(choke_active), 0);

    // R9: rate limit of 4 per 64-edge window
    base = ev_n; ex_n = 0;
    do_sob(20, 4, s);
    put(0, 21); put(4, 22); put(8, 23); put(12, 24); put(16, 25); put(20, 26); put(70, 27);
    expect_ev(s + 22, 0, 0, 21);
    expect_ev(s + 26, 0, 4, 22);
    expect_ev(s + 30, 0, 8, 23);
    expect_ev(s + 34, 0, 12, 24);
    expect_ev(s + 92, 0, 70, 27);
    wait_cyc(s + 40);
    chk("R9 auto_choke set", int'(auto_choke), 1);
    wait_cyc(s + 70);
    chk("R9 auto_choke clear", int'(auto_choke), 0);
    wait_cyc(s + 110);
    compare("R9 rate limit", base);

    chk("R10 host copy mismatches", host_bad, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule